// File: doc/BRIEF.md
# DRAM Self-Refresh Entry/Exit Sequencer

This block sits beside the command scheduler of a DDR SDRAM controller and owns the move into and out of self-refresh. The scheduler asks it to put the memory to sleep or to wake it. The block checks that entry is legal. On entry it drives the clock-enable pin low and places a REFRESH on its command slot in the same cycle. It keeps clock-enable low for the whole sleep.

On exit it raises clock-enable and starts two recovery timers. One gates every command that is not a READ. The other, which is longer, gates READ. It places one AUTO REFRESH of its own once the shorter timer has run out. If the clock frequency changed while the memory was asleep, it pulses a DLL-reset request. It also decides when a second entry is allowed. A new entry is blocked until a full set of AUTO REFRESH commands has gone out. That block is waived when the sleep lasted long enough and the refresh rate since waking has stayed at two or more per refresh interval.

All pins are plain level controls. No data stream passes through the block, so it has no valid/ready interface. The scheduler owns the command bus whenever `cmd_ok` is high. The block drives its own slot only while `cmd_ok` is low.

Top module: `srx_seq`

## Requirements
- R1: A sleep request is accepted only when all of the following hold: the memory is awake, `cmd_ok` is high, no scheduler command is presented in that cycle, `banks_closed` is high, at least TRP cycles have passed since the last precharge was registered, `clk_stable` is high, and `reentry_ok` is high. A refused request sets `err` and leaves `cke` high.
- R2: An accepted sleep request drives `cke` low and `sr_cmd` to REFRESH (2'b01) from the next cycle. `sr_cmd` returns to NOP (2'b00) one cycle later, and `cke` stays low until exit.
- R3: A wake request while asleep takes effect only when `clk_stable` is high. Otherwise it sets `err` and `cke` stays low.
- R4: Cycle 0 is the first cycle with `cke` high after exit. `cmd_ok` is low in cycles 0 to TXSNR, which includes the cycle of the block's own refresh, and high from cycle TXSNR+1 onward.
- R5: With AUTO_AR set, `sr_cmd` is REFRESH in exactly cycle TXSNR after exit and NOP in every other cycle after exit.
- R6: `rd_ok` is low before cycle TXSRD after exit and high from cycle TXSRD onward, where TXSRD > TXSNR.
- R7: `err` is sticky until reset. It is set by a scheduler command presented while its gate is low: a READ needs `rd_ok`, any other command needs `cmd_ok`.
- R8: `dll_reset_req` is a one-cycle pulse in cycle 0 after exit. It fires only if `freq_changed` was seen while the memory was asleep. A change seen while awake has no effect.
- R9: After any exit, `reentry_ok` stays low until NUM_REF AUTO REFRESH commands have been counted, and the block's own refresh counts as one. This holds unless R10 applies.
- R10: If the sleep lasted RES_CYC or more cycles, counted from the entry cycle to the exit cycle, `reentry_ok` is high from cycle 0. It falls after the first TREFI-cycle window since exit that holds fewer than two AUTO REFRESH commands.
- R11: After reset, `cke` is high, `sr_cmd` is NOP, `cmd_ok`, `rd_ok` and `reentry_ok` are high, and `err` and `dll_reset_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Request to enter self-refresh |
| wake_req | input | 1 | Request to leave self-refresh |
| clk_stable | input | 1 | Clock is running within specification |
| freq_changed | input | 1 | Clock frequency was changed in this cycle |
| banks_closed | input | 1 | Every bank is precharged |
| cmd_valid | input | 1 | Scheduler presents a command this cycle |
| cmd_read | input | 1 | The presented command is a READ |
| cmd_ref | input | 1 | The presented command is an AUTO REFRESH |
| cmd_pre | input | 1 | The presented command is a precharge |
| cke | output | 1 | Clock-enable to the memory |
| sr_cmd | output | 2 | Block's command slot: 2'b00 NOP, 2'b01 REFRESH |
| cmd_ok | output | 1 | Scheduler may present a non-READ command |
| rd_ok | output | 1 | Scheduler may present a READ |
| reentry_ok | output | 1 | Self-refresh may be entered again |
| dll_reset_req | output | 1 | One-cycle request for a DLL reset |
| err | output | 1 | Sticky protocol-violation flag |

## Verification
A recovery counter loaded with the wrong value, or off by one, moves the first high cycle of `cmd_ok`, `rd_ok` or the REFRESH slot. The cycle-by-cycle sweep after exit shows the shift within the TXSRD cycles it covers. A residency counter that saturates wrongly flips `reentry_ok` in cycle 0 of the exit, at the RES_CYC boundary. A lost refresh count or window flag shows on `reentry_ok` no later than one window after the missing refresh. An entry or wake gate that is too loose shows at once: `cke` changes and `err` stays low in the cycle after the illegal request.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    SRX_NOP = 2'b00,
    SRX_REF = 2'b01
  } srx_cmd_e;

  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } srx_state_e;
endpackage

// File: rtl/srx_downcnt.sv
module srx_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)             count <= '0;
    else if (load)          count <= load_val;
    else if (count != '0)   count <= count - 1'b1;
  end

  AST_CNT_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (count == '0 && !load) |=> (count == '0)); // R4
endmodule

// File: rtl/srx_reentry.sv
module srx_reentry #(
  parameter int NUM_REF = 8192,
  parameter int TREFI   = 1300,
  parameter int RES_CYC = 33_333_333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic exit_go,
  input  logic asleep,
  input  logic ar_evt,
  output logic reentry_ok
);
  localparam int AW = $clog2(NUM_REF + 1);
  localparam int FW = $clog2(TREFI + 1);
  localparam int RW = $clog2(RES_CYC + 1);

  logic          had_sr, long_q, win_ok;
  logic [AW-1:0] ar_cnt;
  logic [FW-1:0] refi_cnt;
  logic [RW-1:0] res_cnt;
  logic [1:0]    win_ar, win_next;
  logic          end_win;

  assign win_next = win_ar + {1'b0, ar_evt};
  assign end_win  = (refi_cnt == FW'(TREFI - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      had_sr <= 1'b0; long_q <= 1'b0; win_ok <= 1'b0;
      ar_cnt <= '0; refi_cnt <= '0; res_cnt <= '0; win_ar <= '0;
    end else if (enter) begin
      had_sr  <= 1'b1;
      res_cnt <= '0;
    end else if (exit_go) begin
      long_q   <= (res_cnt >= RW'(RES_CYC - 1));
      win_ok   <= 1'b1;
      ar_cnt   <= '0;
      refi_cnt <= '0;
      win_ar   <= '0;
    end else if (asleep) begin
      if (res_cnt < RW'(RES_CYC - 1)) res_cnt <= res_cnt + 1'b1;
    end else if (had_sr) begin
      if (ar_evt && ar_cnt != AW'(NUM_REF)) ar_cnt <= ar_cnt + 1'b1;
      if (end_win) begin
        refi_cnt <= '0;
        win_ar   <= '0;
        if (win_next < 2'd2) win_ok <= 1'b0;
      end else begin
        refi_cnt <= refi_cnt + 1'b1;
        win_ar   <= (win_next > 2'd2) ? 2'd2 : win_next;
      end
    end
  end

  assign reentry_ok = !had_sr || (ar_cnt == AW'(NUM_REF)) || (long_q && win_ok);

  AST_ARCNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) exit_go |=> (ar_cnt == '0)); // R9
endmodule

// File: rtl/srx_seq.sv
module srx_seq import srx_pkg::*; #(
  parameter int TRP     = 3,
  parameter int TXSNR   = 20,
  parameter int TXSRD   = 200,
  parameter int RES_CYC = 33_333_333,
  parameter int TREFI   = 1300,
  parameter int NUM_REF = 8192,
  parameter bit AUTO_AR = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       clk_stable,
  input  logic       freq_changed,
  input  logic       banks_closed,
  input  logic       cmd_valid,
  input  logic       cmd_read,
  input  logic       cmd_ref,
  input  logic       cmd_pre,
  output logic       cke,
  output logic [1:0] sr_cmd,
  output logic       cmd_ok,
  output logic       rd_ok,
  output logic       reentry_ok,
  output logic       dll_reset_req,
  output logic       err
);
  localparam int PW = $clog2(TRP + 1);
  localparam int NW = $clog2(TXSNR + 1);
  localparam int DW = $clog2(TXSRD + 1);

  srx_state_e    state;
  srx_cmd_e      cmd_q;
  logic          cke_q, ar_pend, freq_seen, dll_q, err_q;
  logic [PW-1:0] trp_cnt;
  logic [NW-1:0] xsnr_cnt;
  logic [DW-1:0] xsrd_cnt;
  logic          asleep, entry_ok, enter, exit_go, issue_ar, pre_go, ar_evt, violation;

  assign asleep   = (state == ST_ASLEEP);
  assign cmd_ok   = !asleep && (xsnr_cnt == '0) && !ar_pend && (cmd_q == SRX_NOP);
  assign rd_ok    = cmd_ok && (xsrd_cnt == '0);
  assign entry_ok = cmd_ok && !cmd_valid && banks_closed && (trp_cnt == '0)
                    && clk_stable && reentry_ok;
  assign enter    = sleep_req && entry_ok;
  assign exit_go  = wake_req && asleep && clk_stable;
  assign issue_ar = AUTO_AR && ar_pend && !asleep && (xsnr_cnt == NW'(1));
  assign pre_go   = cmd_valid && cmd_pre && cmd_ok;
  assign ar_evt   = issue_ar || (cmd_valid && cmd_ref && cmd_ok);
  assign violation = (sleep_req && !asleep && !entry_ok)
                   || (wake_req && asleep && !clk_stable)
                   || (cmd_valid && (cmd_read ? !rd_ok : !cmd_ok));

  srx_downcnt #(.W(PW)) u_trp (
    .clk(clk), .rst_n(rst_n), .load(pre_go), .load_val(PW'(TRP)), .count(trp_cnt));
  srx_downcnt #(.W(NW)) u_xsnr (
    .clk(clk), .rst_n(rst_n), .load(exit_go), .load_val(NW'(TXSNR)), .count(xsnr_cnt));
  srx_downcnt #(.W(DW)) u_xsrd (
    .clk(clk), .rst_n(rst_n), .load(exit_go), .load_val(DW'(TXSRD)), .count(xsrd_cnt));

  srx_reentry #(.NUM_REF(NUM_REF), .TREFI(TREFI), .RES_CYC(RES_CYC)) u_reent (
    .clk(clk), .rst_n(rst_n), .enter(enter), .exit_go(exit_go), .asleep(asleep),
    .ar_evt(ar_evt), .reentry_ok(reentry_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_AWAKE; cmd_q <= SRX_NOP; cke_q <= 1'b1;
      ar_pend <= 1'b0; freq_seen <= 1'b0; dll_q <= 1'b0; err_q <= 1'b0;
    end else begin
      cmd_q <= SRX_NOP;
      dll_q <= 1'b0;
      err_q <= err_q || violation;
      if (enter) begin
        state     <= ST_ASLEEP;
        cke_q     <= 1'b0;
        cmd_q     <= SRX_REF;
        freq_seen <= 1'b0;
      end else if (exit_go) begin
        state     <= ST_AWAKE;
        cke_q     <= 1'b1;
        ar_pend   <= AUTO_AR;
        dll_q     <= freq_seen || freq_changed;
        freq_seen <= 1'b0;
      end else if (asleep && freq_changed) begin
        freq_seen <= 1'b1;
      end
      if (issue_ar) begin
        cmd_q   <= SRX_REF;
        ar_pend <= 1'b0;
      end
    end
  end

  assign cke           = cke_q;
  assign sr_cmd        = cmd_q;
  assign dll_reset_req = dll_q;
  assign err           = err_q;

  AST_ENTRY_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) $fell(cke_q) |-> ($past(banks_closed) && $past(trp_cnt == '0))); // R1
  AST_ENTRY_REF:     assert property (@(posedge clk) disable iff (!rst_n) $fell(cke_q) |-> (cmd_q == SRX_REF)); // R2
  AST_EXIT_STABLE:   assert property (@(posedge clk) disable iff (!rst_n) $rose(cke_q) |-> $past(clk_stable)); // R3
  AST_NO_CMD_EARLY:  assert property (@(posedge clk) disable iff (!rst_n) $rose(cke_q) |=> !cmd_ok); // R4
  AST_NO_READ_EARLY: assert property (@(posedge clk) disable iff (!rst_n) $rose(cke_q) |=> !rd_ok); // R6
  AST_ERR_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) err_q |=> err_q); // R7
  AST_DLL_ON_EXIT:   assert property (@(posedge clk) disable iff (!rst_n) dll_q |-> $rose(cke_q)); // R8
endmodule

// File: tb/sim_srx_seq.sv
module sim_srx_seq;
  localparam int P_TRP   = 3;
  localparam int P_TXSNR = 6;
  localparam int P_TXSRD = 12;
  localparam int P_RES   = 20;
  localparam int P_TREFI = 16;
  localparam int P_NREF  = 8;

  logic clk = 1'b0;
  logic rst_n, sleep_req, wake_req, clk_stable, freq_changed, banks_closed;
  logic cmd_valid, cmd_read, cmd_ref, cmd_pre;
  logic cke, cmd_ok, rd_ok, reentry_ok, dll_reset_req, err;
  logic [1:0] sr_cmd;
  int vec = 0;
  int bad = 0;

  always #10 clk = ~clk;

  srx_seq #(.TRP(P_TRP), .TXSNR(P_TXSNR), .TXSRD(P_TXSRD), .RES_CYC(P_RES),
            .TREFI(P_TREFI), .NUM_REF(P_NREF), .AUTO_AR(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .clk_stable(clk_stable), .freq_changed(freq_changed), .banks_closed(banks_closed),
    .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_ref(cmd_ref), .cmd_pre(cmd_pre),
    .cke(cke), .sr_cmd(sr_cmd), .cmd_ok(cmd_ok), .rd_ok(rd_ok), .reentry_ok(reentry_ok),
    .dll_reset_req(dll_reset_req), .err(err));

  task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sleep_req = 1'b0; wake_req = 1'b0; clk_stable = 1'b1;
    freq_changed = 1'b0; banks_closed = 1'b1;
    cmd_valid = 1'b0; cmd_read = 1'b0; cmd_ref = 1'b0; cmd_pre = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic exit_after(input int k);
    repeat (k - 1) @(negedge clk);
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
  endtask

  task automatic issue(input logic rd, input logic rf, input logic pr);
    cmd_valid = 1'b1; cmd_read = rd; cmd_ref = rf; cmd_pre = pr;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_read = 1'b0; cmd_ref = 1'b0; cmd_pre = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    chk("R11", "cke", {1'b0, cke}, 2'd1);
    chk("R11", "sr_cmd", sr_cmd, 2'd0);
    chk("R11", "cmd_ok", {1'b0, cmd_ok}, 2'd1);
    chk("R11", "rd_ok", {1'b0, rd_ok}, 2'd1);
    chk("R11", "reentry_ok", {1'b0, reentry_ok}, 2'd1);
    chk("R11", "err", {1'b0, err}, 2'd0);
    chk("R11", "dll", {1'b0, dll_reset_req}, 2'd0);

    // R2 entry: cke low with REFRESH, then NOP, cke held
    pulse_sleep();
    chk("R2", "cke at entry", {1'b0, cke}, 2'd0);
    chk("R2", "sr_cmd at entry", sr_cmd, 2'd1);
    @(negedge clk);
    chk("R2", "sr_cmd after entry", sr_cmd, 2'd0);
    repeat (10) @(negedge clk);
    chk("R2", "cke held", {1'b0, cke}, 2'd0);
    chk("R2", "err", {1'b0, err}, 2'd0);
    // R3 wake with unstable clock
    clk_stable = 1'b0; wake_req = 1'b1; @(negedge clk); wake_req = 1'b0; clk_stable = 1'b1;
    chk("R3", "cke stays low", {1'b0, cke}, 2'd0);
    chk("R3", "err", {1'b0, err}, 2'd1);

    // R4 R5 R6 sweep after exit
    do_reset(); pulse_sleep(); exit_after(5);
    for (int n = 0; n <= P_TXSRD + 2; n++) begin
      chk("R4", $sformatf("cmd_ok n=%0d", n), {1'b0, cmd_ok}, {1'b0, n >= P_TXSNR + 1});
      chk("R5", $sformatf("sr_cmd n=%0d", n), sr_cmd, (n == P_TXSNR) ? 2'd1 : 2'd0);
      chk("R6", $sformatf("rd_ok n=%0d", n), {1'b0, rd_ok}, {1'b0, n >= P_TXSRD});
      chk("R4", $sformatf("cke n=%0d", n), {1'b0, cke}, 2'd1);
      @(negedge clk);
    end
    chk("R7", "no err on clean exit", {1'b0, err}, 2'd0);

    // R7 early commands
    do_reset(); pulse_sleep(); exit_after(3);
    repeat (P_TXSNR) @(negedge clk);
    issue(1'b0, 1'b0, 1'b0);
    chk("R7", "non-read during refresh slot", {1'b0, err}, 2'd1);
    do_reset(); pulse_sleep(); exit_after(3);
    repeat (P_TXSNR + 1) @(negedge clk);
    issue(1'b0, 1'b0, 1'b0);
    chk("R4", "non-read at first legal cycle", {1'b0, err}, 2'd0);
    repeat (P_TXSRD - 1 - (P_TXSNR + 2)) @(negedge clk);
    issue(1'b1, 1'b0, 1'b0);
    chk("R7", "read one cycle early", {1'b0, err}, 2'd1);
    do_reset(); pulse_sleep(); exit_after(3);
    repeat (P_TXSRD) @(negedge clk);
    issue(1'b1, 1'b0, 1'b0);
    chk("R6", "read at first legal cycle", {1'b0, err}, 2'd0);

    // R1 refusals and precharge timing
    do_reset(); banks_closed = 1'b0; pulse_sleep(); banks_closed = 1'b1;
    chk("R1", "open bank cke", {1'b0, cke}, 2'd1);
    chk("R1", "open bank err", {1'b0, err}, 2'd1);
    do_reset(); issue(1'b0, 1'b0, 1'b1);
    repeat (P_TRP - 1) @(negedge clk);
    pulse_sleep();
    chk("R1", "tRP-1 cke", {1'b0, cke}, 2'd1);
    chk("R1", "tRP-1 err", {1'b0, err}, 2'd1);
    do_reset(); issue(1'b0, 1'b0, 1'b1);
    repeat (P_TRP) @(negedge clk);
    pulse_sleep();
    chk("R1", "tRP cke", {1'b0, cke}, 2'd0);
    chk("R1", "tRP err", {1'b0, err}, 2'd0);
    do_reset(); clk_stable = 1'b0; pulse_sleep(); clk_stable = 1'b1;
    chk("R1", "unstable clock cke", {1'b0, cke}, 2'd1);
    chk("R1", "unstable clock err", {1'b0, err}, 2'd1);

    // R8 DLL reset request
    do_reset(); pulse_sleep(); @(negedge clk);
    freq_changed = 1'b1; @(negedge clk); freq_changed = 1'b0;
    exit_after(5);
    chk("R8", "dll at exit", {1'b0, dll_reset_req}, 2'd1);
    @(negedge clk);
    chk("R8", "dll one cycle", {1'b0, dll_reset_req}, 2'd0);
    do_reset(); freq_changed = 1'b1; @(negedge clk); freq_changed = 1'b0;
    pulse_sleep(); exit_after(5);
    chk("R8", "awake change ignored", {1'b0, dll_reset_req}, 2'd0);

    // R9 short sleep: refresh count rule
    do_reset(); pulse_sleep(); exit_after(P_RES - 1);
    chk("R9", "reentry at exit", {1'b0, reentry_ok}, 2'd0);
    repeat (P_TXSNR + 1) @(negedge clk);
    for (int i = 0; i < P_NREF - 2; i++) issue(1'b0, 1'b1, 1'b0);
    chk("R9", "one refresh short", {1'b0, reentry_ok}, 2'd0);
    pulse_sleep();
    chk("R9", "blocked entry cke", {1'b0, cke}, 2'd1);
    chk("R9", "blocked entry err", {1'b0, err}, 2'd1);
    issue(1'b0, 1'b1, 1'b0);
    chk("R9", "full count", {1'b0, reentry_ok}, 2'd1);
    pulse_sleep();
    chk("R9", "re-entry taken", {1'b0, cke}, 2'd0);

    // R10 residency boundary sweep
    for (int k = P_RES - 2; k <= P_RES + 1; k++) begin
      do_reset(); pulse_sleep(); exit_after(k);
      chk("R10", $sformatf("residency %0d", k), {1'b0, reentry_ok}, {1'b0, k >= P_RES});
    end

    // R10 refresh-rate windows after a long sleep
    do_reset(); pulse_sleep(); exit_after(P_RES + 5);
    repeat (8) @(negedge clk);
    issue(1'b0, 1'b1, 1'b0);
    repeat (8) @(negedge clk);
    chk("R10", "window 1 two refreshes", {1'b0, reentry_ok}, 2'd1);
    @(negedge clk);
    issue(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    issue(1'b0, 1'b1, 1'b0);
    repeat (12) @(negedge clk);
    chk("R10", "window 2 two refreshes", {1'b0, reentry_ok}, 2'd1);
    repeat (16) @(negedge clk);
    chk("R10", "window 3 starved", {1'b0, reentry_ok}, 2'd0);
    chk("R7", "no err in window test", {1'b0, err}, 2'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule